// File: doc/BRIEF.md
# Masked-Write GPIO Bank Register File

This block is the register file for one bank of 32 general-purpose pins, grouped as four ports of eight pins each. A host on a simple 32-bit register bus writes per-port mode, drive-enable, drive-value, interrupt-enable and interrupt-type bytes. It reads those bytes back, together with the synchronized pin levels and the interrupt status that a separate detector supplies. Pin `8*p + n` belongs to port `p`, bit `n`.

Every writable byte is also reachable through a second, aliased window that starts `UPPER_OFS` bytes above the plain one. A write through this alias carries its own per-bit mask in data bits 15:8, so a single pin changes in one bus write, with no read-modify-write. Interrupt detection is outside this block. Status reads come in on `irq_sts_i`, and clear or set requests leave as one-cycle pulses on `sts_clr_o` and `sts_set_o`.

Address decoding uses byte addresses. The register class sits in offset bits 6:4 and the port in offset bits 3:2:
- 0 = mode
- 1 = drive enable
- 2 = drive value
- 3 = pin input
- 4 = interrupt status
- 5 = interrupt enable
- 6 = interrupt type
- 7 = interrupt clear

Top module: `gpio_bank_regs`

## Requirements
- R1: After reset, all stored registers are 0. `pin_oe_o`, `pin_out_o`, `irq_en_o` and `irq_type_o` are all 0 and `rdata_o` reads 0 for stored classes.
- R2: A plain write (offset below 0x80) to class 0, 1, 2, 5 or 6 replaces that port's byte with `wdata_i[7:0]` and ignores `wdata_i[31:8]`. A read of the same address returns the byte in `rdata_o[7:0]` with the upper bits 0.
- R3: A write through the masked window (`UPPER_OFS` + offset) updates only those bits n of the port byte for which `wdata_i[8+n]` is 1, taking the new value from `wdata_i[n]`. All other bits keep their value.
- R4: `pin_oe_o[i]` is 1 exactly when both mode bit i and drive-enable bit i are 1. `pin_out_o` carries the drive-value register.
- R5: The input class returns the pin levels through a two-flop synchronizer. A level change is not visible after one rising edge and is visible after the second.
- R6: Reading a masked-window address of classes 0, 1, 2, 4, 5 or 6 returns the same value as the plain address.
- R7: A read of class 4 returns `irq_sts_i` for that port. A plain write to class 7 pulses `sts_clr_o` at the port's bit positions with `wdata_i[7:0]` for exactly one cycle after the write edge. With no write, both pulse outputs are 0.
- R8: A masked write to class 4 pulses `sts_set_o` for bits with mask 1 and value 1, and `sts_clr_o` for bits with mask 1 and value 0. The two outputs never share a set bit.
- R9: Writes to misaligned addresses, to addresses outside both windows, to the input class, to plain status, and to masked input or clear offsets change nothing. Reads of those addresses, and of any clear offset, return 0.
- R10: Port index p = offset bits 3:2 selects pins 8p to 8p+7. A write to one port leaves the other ports' bits unchanged.
- R11: `irq_en_o` and `irq_type_o` carry the interrupt-enable and interrupt-type registers of all four ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | AW | Byte address |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data; bits 15:8 are the mask in the alias window |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| pin_in_i | input | 32 | Pin levels, asynchronous |
| pin_out_o | output | 32 | Drive values |
| pin_oe_o | output | 32 | Drive enables (mode AND drive-enable) |
| irq_sts_i | input | 32 | Interrupt status from the detector |
| irq_en_o | output | 32 | Interrupt enables |
| irq_type_o | output | 32 | Interrupt types |
| sts_clr_o | output | 32 | One-cycle status clear pulses |
| sts_set_o | output | 32 | One-cycle status set pulses |

## Verification
The bench targets the masked merge with a partial mask over a non-zero old value. A design that merged wrongly, or applied the mask in the plain window, would leave a wrong byte on `pin_out_o`. It checks the drive-enable gating, the port lane selection and the alias read-back, which would expose a swapped lane or an alias that reads 0. It times the synchronizer edge by edge, so a one-flop or three-flop path fails. It also drives misaligned, out-of-window and read-only addresses, where a loose decoder would corrupt a port or produce a stray status pulse.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int NPORT  = 4;
  localparam int PORT_W = 8;
  localparam int PINS   = NPORT * PORT_W;
  localparam int PSEL_W = $clog2(NPORT);
  localparam int WIN_W  = 7;  // 128-byte window: class[6:4], port[3:2]

  typedef enum logic [2:0] {
    CLS_MODE = 3'd0,
    CLS_DREN = 3'd1,
    CLS_DVAL = 3'd2,
    CLS_PIN  = 3'd3,
    CLS_STS  = 3'd4,
    CLS_IEN  = 3'd5,
    CLS_ITYP = 3'd6,
    CLS_ICLR = 3'd7
  } reg_cls_e;

  function automatic logic [PORT_W-1:0] merge_bits(
    input logic [PORT_W-1:0] old_v,
    input logic [PORT_W-1:0] new_v,
    input logic [PORT_W-1:0] sel
  );
    return (old_v & ~sel) | (new_v & sel);
  endfunction
endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
  import gpio_bank_pkg::*;
#(
  parameter int AW        = 12,
  parameter int UPPER_OFS = 'h80
) (
  input  logic [AW-1:0]     addr_i,
  output logic              hit_o,
  output logic              masked_o,
  output reg_cls_e          cls_o,
  output logic [PSEL_W-1:0] port_o
);
  localparam logic [AW-1:0] UPPER = AW'(UPPER_OFS);

  logic [AW-1:0]    rel_m;
  logic             plain_win, mask_win;
  logic [WIN_W-1:0] off;
  logic             cls_ok;

  assign rel_m     = addr_i - UPPER;
  assign plain_win = (addr_i[AW-1:WIN_W] == '0);
  assign mask_win  = !plain_win && (addr_i >= UPPER) && (rel_m[AW-1:WIN_W] == '0);
  assign off       = plain_win ? addr_i[WIN_W-1:0] : rel_m[WIN_W-1:0];
  assign cls_o     = reg_cls_e'(off[6:4]);
  assign port_o    = off[3:2];
  assign masked_o  = mask_win;

  // alias window has no input or clear class
  assign cls_ok = plain_win || !(cls_o inside {CLS_PIN, CLS_ICLR});
  assign hit_o  = (plain_win || mask_win) && (off[1:0] == 2'b00) && cls_ok;
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] chain_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     chain_q[s] <= '0;
      else if (s == 0) chain_q[s] <= d_i;
      else             chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_bank_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              masked_i,
  input  reg_cls_e          cls_i,
  input  logic [15:0]       wdata_i,
  output logic [PORT_W-1:0] mode_o,
  output logic [PORT_W-1:0] dren_o,
  output logic [PORT_W-1:0] dval_o,
  output logic [PORT_W-1:0] ien_o,
  output logic [PORT_W-1:0] ityp_o,
  output logic [PORT_W-1:0] set_o,
  output logic [PORT_W-1:0] clr_o
);
  logic [PORT_W-1:0] val, sel;

  assign val = wdata_i[PORT_W-1:0];
  assign sel = masked_i ? wdata_i[2*PORT_W-1:PORT_W] : '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o <= '0;
      dren_o <= '0;
      dval_o <= '0;
      ien_o  <= '0;
      ityp_o <= '0;
      set_o  <= '0;
      clr_o  <= '0;
    end else begin
      set_o <= '0;
      clr_o <= '0;
      if (wr_i) begin
        unique case (cls_i)
          CLS_MODE: mode_o <= merge_bits(mode_o, val, sel);
          CLS_DREN: dren_o <= merge_bits(dren_o, val, sel);
          CLS_DVAL: dval_o <= merge_bits(dval_o, val, sel);
          CLS_IEN:  ien_o  <= merge_bits(ien_o,  val, sel);
          CLS_ITYP: ityp_o <= merge_bits(ityp_o, val, sel);
          CLS_STS: if (masked_i) begin
            set_o <= sel & val;
            clr_o <= sel & ~val;
          end
          CLS_ICLR: clr_o <= val;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_bank_pkg::*;
#(
  parameter int AW          = 12,
  parameter int UPPER_OFS   = 'h80,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          wr_i,
  input  logic [31:0]   wdata_i,
  output logic [31:0]   rdata_o,
  input  logic [31:0]   pin_in_i,
  output logic [31:0]   pin_out_o,
  output logic [31:0]   pin_oe_o,
  input  logic [31:0]   irq_sts_i,
  output logic [31:0]   irq_en_o,
  output logic [31:0]   irq_type_o,
  output logic [31:0]   sts_clr_o,
  output logic [31:0]   sts_set_o
);
  logic              hit, masked;
  reg_cls_e          cls;
  logic [PSEL_W-1:0] port;
  logic [PINS-1:0]   pin_sync;

  logic [NPORT-1:0][PORT_W-1:0] mode_q, dren_q, dval_q, ien_q, ityp_q, set_q, clr_q;

  gpio_addr_dec #(.AW(AW), .UPPER_OFS(UPPER_OFS)) u_dec (
    .addr_i  (addr_i),
    .hit_o   (hit),
    .masked_o(masked),
    .cls_o   (cls),
    .port_o  (port)
  );

  gpio_in_sync #(.W(PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_in_i),
    .q_o   (pin_sync)
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    logic wr_p;
    assign wr_p = wr_i && hit && (port == PSEL_W'(p));

    gpio_port_regs u_port (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (wr_p),
      .masked_i(masked),
      .cls_i   (cls),
      .wdata_i (wdata_i[15:0]),
      .mode_o  (mode_q[p]),
      .dren_o  (dren_q[p]),
      .dval_o  (dval_q[p]),
      .ien_o   (ien_q[p]),
      .ityp_o  (ityp_q[p]),
      .set_o   (set_q[p]),
      .clr_o   (clr_q[p])
    );
  end

  assign pin_out_o  = dval_q;
  assign pin_oe_o   = mode_q & dren_q;
  assign irq_en_o   = ien_q;
  assign irq_type_o = ityp_q;
  assign sts_clr_o  = clr_q;
  assign sts_set_o  = set_q;

  logic [NPORT-1:0][PORT_W-1:0] pin_b, sts_b;
  assign pin_b = pin_sync;
  assign sts_b = irq_sts_i;

  always_comb begin
    rdata_o = '0;
    if (hit) begin
      unique case (cls)
        CLS_MODE: rdata_o[PORT_W-1:0] = mode_q[port];
        CLS_DREN: rdata_o[PORT_W-1:0] = dren_q[port];
        CLS_DVAL: rdata_o[PORT_W-1:0] = dval_q[port];
        CLS_PIN:  rdata_o[PORT_W-1:0] = pin_b[port];
        CLS_STS:  rdata_o[PORT_W-1:0] = sts_b[port];
        CLS_IEN:  rdata_o[PORT_W-1:0] = ien_q[port];
        CLS_ITYP: rdata_o[PORT_W-1:0] = ityp_q[port];
        default:  rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_bank_regs_chk.sv
module gpio_bank_regs_chk #(
  parameter int AW        = 12,
  parameter int UPPER_OFS = 'h80
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [AW-1:0] addr_i,
  input logic          wr_i,
  input logic [31:0]   wdata_i,
  input logic [31:0]   pin_out_o,
  input logic [31:0]   pin_oe_o,
  input logic [31:0]   irq_en_o,
  input logic [31:0]   irq_type_o,
  input logic [31:0]   sts_clr_o,
  input logic [31:0]   sts_set_o
);
  localparam logic [AW:0] LO_M = (AW+1)'(UPPER_OFS);
  localparam logic [AW:0] HI_M = (AW+1)'(UPPER_OFS + 128);

  logic in_mask_win, outside;
  assign in_mask_win = ({1'b0, addr_i} >= LO_M) && ({1'b0, addr_i} < HI_M);
  assign outside     = ({1'b0, addr_i} >= HI_M) ||
                       (({1'b0, addr_i} >= (AW+1)'(128)) && ({1'b0, addr_i} < LO_M));

  always @(negedge clk_i)
    if (!rst_ni)
      a_r1_reset_idle: assert (pin_oe_o == '0 && pin_out_o == '0 && irq_en_o == '0 &&
                               irq_type_o == '0 && sts_clr_o == '0 && sts_set_o == '0);

  a_r2_hold_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(pin_out_o) && $stable(pin_oe_o) && $stable(irq_en_o) && $stable(irq_type_o));

  a_r3_empty_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && in_mask_win && wdata_i[15:8] == 8'h00) |=>
      $stable(pin_out_o) && $stable(pin_oe_o) && $stable(irq_en_o) && $stable(irq_type_o) &&
      sts_set_o == '0 && sts_clr_o == '0);

  a_r7_pulse_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> (sts_clr_o == '0 && sts_set_o == '0));

  a_r8_set_clr_disjoint: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_set_o & sts_clr_o) == '0);

  a_r9_outside_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && outside) |=> $stable(pin_out_o) && $stable(pin_oe_o) && $stable(irq_en_o) &&
      $stable(irq_type_o) && sts_clr_o == '0 && sts_set_o == '0);
endmodule

bind gpio_bank_regs gpio_bank_regs_chk #(.AW(AW), .UPPER_OFS(UPPER_OFS)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .addr_i    (addr_i),
  .wr_i      (wr_i),
  .wdata_i   (wdata_i),
  .pin_out_o (pin_out_o),
  .pin_oe_o  (pin_oe_o),
  .irq_en_o  (irq_en_o),
  .irq_type_o(irq_type_o),
  .sts_clr_o (sts_clr_o),
  .sts_set_o (sts_set_o)
);

// File: tb/tb_gpio_bank_regs.sv
`timescale 1ns/1ps
module tb_gpio_bank_regs;
  localparam int AW = 12;
  localparam int MW = 'h80;  // alias window base

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic          wr_i = 1'b0;
  logic [31:0]   wdata_i = '0;
  logic [31:0]   rdata_o, pin_in_i, pin_out_o, pin_oe_o, irq_sts_i;
  logic [31:0]   irq_en_o, irq_type_o, sts_clr_o, sts_set_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  gpio_bank_regs #(.AW(AW), .UPPER_OFS(MW)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_i(wr_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .pin_in_i(pin_in_i), .pin_out_o(pin_out_o), .pin_oe_o(pin_oe_o),
    .irq_sts_i(irq_sts_i), .irq_en_o(irq_en_o), .irq_type_o(irq_type_o),
    .sts_clr_o(sts_clr_o), .sts_set_o(sts_set_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(negedge clk_i);
    wr_i = 1'b0; wdata_i = '0;
  endtask

  task automatic bus_rd(input logic [AW-1:0] a, output logic [31:0] v);
    @(negedge clk_i);
    addr_i = a; wr_i = 1'b0;
    #1 v = rdata_o;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    bus_rd(12'h020, v);
    chk("R1 drive value reads 0", v, 0);
    chk("R1 pin_oe_o", pin_oe_o, 0);
    chk("R1 pin_out_o", pin_out_o, 0);
    chk("R1 irq_en_o", irq_en_o | irq_type_o, 0);
  endtask

  task automatic t_plain;
    logic [31:0] v;
    bus_wr(12'h024, 32'hFFFF_FFA5);  // port 1, upper bits ignored
    chk("R2 R10 plain drive value lane", pin_out_o, 32'h0000_A500);
    bus_rd(12'h024, v);
    chk("R2 plain read back", v, 32'h0000_00A5);
    bus_wr(12'h02C, 32'h0000_0011);  // port 3
    chk("R10 other port untouched", pin_out_o, 32'h1100_A500);
  endtask

  task automatic t_masked;
    logic [31:0] v;
    bus_wr(MW + 12'h024, 32'h0000_0F0A);
    chk("R3 partial mask merge", pin_out_o, 32'h1100_AA00);
    bus_rd(MW + 12'h024, v);
    chk("R6 alias read equals plain", v, 32'h0000_00AA);
    bus_wr(MW + 12'h02C, 32'h0000_01FE);  // only bit0 -> 0
    chk("R3 single bit clear", pin_out_o, 32'h1000_AA00);
  endtask

  task automatic t_oe;
    bus_wr(12'h008, 32'h0000_00F0);  // mode port 2
    chk("R4 mode only gives no drive", pin_oe_o, 0);
    bus_wr(12'h018, 32'h0000_003C);  // drive enable port 2
    chk("R4 oe gating", pin_oe_o, 32'h0030_0000);
  endtask

  task automatic t_input;
    logic [31:0] v;
    @(negedge clk_i);
    addr_i = 12'h030;
    pin_in_i = 32'h1234_5678;
    #1 chk("R5 no change before edge", rdata_o, 0);
    @(negedge clk_i);
    #1 chk("R5 hidden after one edge", rdata_o, 0);
    @(negedge clk_i);
    #1 chk("R5 visible after two edges", rdata_o, 32'h78);
    bus_rd(12'h034, v);
    chk("R5 port 1 input", v, 32'h56);
  endtask

  task automatic t_status;
    logic [31:0] v;
    bus_rd(12'h04C, v);
    chk("R7 status read port 3", v, 32'hDE);
    @(negedge clk_i);
    addr_i = 12'h078; wdata_i = 32'h0000_0081; wr_i = 1'b1;
    @(negedge clk_i);
    wr_i = 1'b0;
    chk("R7 clear pulse", sts_clr_o, 32'h0081_0000);
    chk("R7 no set on clear", sts_set_o, 0);
    @(negedge clk_i);
    chk("R7 pulse one cycle", sts_clr_o, 0);
    @(negedge clk_i);
    addr_i = MW + 12'h040; wdata_i = 32'h0000_0301; wr_i = 1'b1;
    @(negedge clk_i);
    wr_i = 1'b0;
    chk("R8 masked status set", sts_set_o, 32'h01);
    chk("R8 masked status clear", sts_clr_o, 32'h02);
    @(negedge clk_i);
    chk("R8 pulses drop", sts_set_o | sts_clr_o, 0);
  endtask

  task automatic t_irq;
    bus_wr(MW + 12'h05C, 32'h0000_8080);
    chk("R11 irq enable bit31", irq_en_o, 32'h8000_0000);
    bus_wr(12'h060, 32'h0000_0055);
    chk("R11 irq type port0", irq_type_o, 32'h0000_0055);
  endtask

  task automatic t_undecoded;
    logic [31:0] v;
    bus_wr(12'h220, 32'h0000_FFFF);
    chk("R9 out of window write", pin_out_o, 32'h1000_AA00);
    bus_rd(12'h220, v);
    chk("R9 out of window read", v, 0);
    bus_wr(12'h021, 32'h0000_FFFF);
    chk("R9 misaligned write", pin_out_o, 32'h1000_AA00);
    bus_wr(12'h040, 32'h0000_FFFF);  // plain status write
    chk("R9 plain status write no pulse", sts_clr_o | sts_set_o, 0);
    bus_wr(MW + 12'h070, 32'h0000_FFFF);
    chk("R9 masked clear offset no pulse", sts_clr_o | sts_set_o, 0);
    bus_rd(MW + 12'h030, v);
    chk("R9 masked input read", v, 0);
    bus_rd(12'h070, v);
    chk("R9 clear reads 0", v, 0);
  endtask

  initial begin
    pin_in_i = '0;
    irq_sts_i = 32'hDEAD_BEEF;
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    t_reset();
    t_plain();
    t_masked();
    t_oe();
    t_input();
    t_status();
    t_irq();
    t_undecoded();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule